// File: doc/BRIEF.md
# Sound Card DMA Pacing Controller

This block is the host-bus side of an 8-bit audio card that moves samples by DMA at a programmable rate. It claims a 16-byte I/O window whose base is picked by two jumper inputs, and decodes only the upper eight offsets of that window. Software loads a 16-bit rate divisor one byte at a time. A free-running pacing counter then paces the card's DMA request. Each acknowledged byte drops the request, and the next counter expiry raises it again.

Three of the decoded offsets are action ports: a write of any value enables the request path, disables it, or clears the interrupt. The host DMA controller's terminal-count signal latches an interrupt that holds until the clear port is written. Jumper inputs route the request and acknowledge to one of two DMA channels, and the interrupt to one of two interrupt lines. A direct DAC data port lets software write samples by hand while DMA is off.

Top module: `dmaPacer`

## Requirements
- R1: A write is accepted only when address bits [9:4] equal the window chosen by `baseSel` (0: 0x22, 1: 0x24, 2: 0x28, 3: 0x2C) and address bit 3 is 1. Offsets 0x0 to 0x7 of the window and all other addresses are ignored.
- R2: After reset the request and both interrupt lines are low, the request path is disabled, the DAC register holds 0 and the divisor is 65536.
- R3: A write of any value to offset 0xE enables the request path, raises the request on the next clock and restarts the pacing counter from the divisor N.
- R4: An acknowledge on the selected channel while the request is high drops the request on the next clock. The request rises again only on the next counter expiry. Expiries recur every N clocks, counted from the enable write or the last reload.
- R5: A write of any value to offset 0xD drops the request and keeps it low until the next enable write.
- R6: The divisor is written to offset 0xA, low byte first and then high byte. It takes effect, with the counter reloaded, only when the high byte arrives. A low byte alone changes no timing. A divisor of 0 means 65536.
- R7: A write to offset 0xB with data bits [7:6] = 2'b10 makes the next offset-0xA write a low byte.
- R8: A terminal-count pulse sets the interrupt, which stays set until a write of any value to offset 0xC. If terminal count and the clear write fall in the same cycle, the interrupt stays set.
- R9: `chanSel` = 0 routes the request and acknowledge to channel 1 and `chanSel` = 1 routes them to channel 3. `irqSel` = 0 selects interrupt line 3 and `irqSel` = 1 selects line 7. Unselected outputs stay low, and an acknowledge on the unselected channel is ignored.
- R10: A write to offset 0xF loads `dacData` while the request path is disabled. The write is ignored while it is enabled.
- R11: When an acknowledge and a counter expiry fall in the same cycle, the acknowledge wins. The request goes low and stays low until the following expiry, N clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the pacing time base |
| rstN | input | 1 | Active-low synchronous reset |
| baseSel | input | 2 | Jumper selection of the I/O window |
| chanSel | input | 1 | DMA channel jumper: 0 for channel 1, 1 for channel 3 |
| irqSel | input | 1 | Interrupt jumper: 0 for line 3, 1 for line 7 |
| ioAddr | input | 10 | Host I/O address |
| ioWrData | input | 8 | Host write data |
| ioWr | input | 1 | One-cycle host write strobe |
| dackCh1 | input | 1 | DMA acknowledge, channel 1 |
| dackCh3 | input | 1 | DMA acknowledge, channel 3 |
| tcIn | input | 1 | Terminal-count pulse from the host DMA controller |
| drqCh1 | output | 1 | DMA request, channel 1 |
| drqCh3 | output | 1 | DMA request, channel 3 |
| irqLine3 | output | 1 | Interrupt line 3 |
| irqLine7 | output | 1 | Interrupt line 7 |
| dacData | output | 8 | Direct DAC sample register |

## Verification
The acknowledge that drops the request and the pacing expiry that raises it can fall in the same cycle. The bench provokes this by counting exactly N clocks from a known reload and placing a one-cycle acknowledge on the expiry edge. It then expects the request low at once, still low one clock before the next expiry, and high N clocks after the collision. A similar collision pairs a terminal-count pulse with a clear-port write, and the interrupt line must remain high afterwards.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  // Low nibble of each decoded window offset
  localparam logic [3:0] OFF_DIV = 4'hA;
  localparam logic [3:0] OFF_CTL = 4'hB;
  localparam logic [3:0] OFF_CLR = 4'hC;
  localparam logic [3:0] OFF_DIS = 4'hD;
  localparam logic [3:0] OFF_ENA = 4'hE;
  localparam logic [3:0] OFF_DAC = 4'hF;

  // Control-port selector that rewinds the divisor byte order
  localparam logic [1:0] CTL_PACER_SEL = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic restart;
    logic dacWrite;
  } pacerStrb_t;

endpackage

// File: rtl/pacerCtrl.sv
module pacerCtrl
  import pacer_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        baseSel,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic [1:0]        modeBits,
  input  logic              ackSel,
  input  logic              tcIn,
  input  logic              expire,
  output pacerStrb_t        strb,
  output logic              reqFlag,
  output logic              irqFlag
);

  localparam int WIN_LSB = 4;

  logic [ADDR_W-1:0] baseAddr;
  logic              winHit;
  logic              wrDiv, wrCtl, wrClr, wrDis, wrEna, wrDac;
  logic              hiNext;
  logic              enabled;

  always_comb begin
    case (baseSel)
      2'd0:    baseAddr = ADDR_W'('h220);
      2'd1:    baseAddr = ADDR_W'('h240);
      2'd2:    baseAddr = ADDR_W'('h280);
      default: baseAddr = ADDR_W'('h2C0);
    endcase
  end

  // Upper half of the window only
  assign winHit = ioWr && ioAddr[3]
                  && (ioAddr[ADDR_W-1:WIN_LSB] == baseAddr[ADDR_W-1:WIN_LSB]);

  assign wrDiv = winHit && (ioAddr[3:0] == OFF_DIV);
  assign wrCtl = winHit && (ioAddr[3:0] == OFF_CTL);
  assign wrClr = winHit && (ioAddr[3:0] == OFF_CLR);
  assign wrDis = winHit && (ioAddr[3:0] == OFF_DIS);
  assign wrEna = winHit && (ioAddr[3:0] == OFF_ENA);
  assign wrDac = winHit && (ioAddr[3:0] == OFF_DAC);

  // Divisor byte order: low, then high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiNext <= 1'b0;
    end else if (wrCtl && (modeBits == CTL_PACER_SEL)) begin
      hiNext <= 1'b0;
    end else if (wrDiv) begin
      hiNext <= ~hiNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enabled <= 1'b0;
    end else if (wrDis) begin
      enabled <= 1'b0;
    end else if (wrEna) begin
      enabled <= 1'b1;
    end
  end

  // Request: disable > enable > acknowledge > expiry re-arm
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqFlag <= 1'b0;
    end else if (wrDis) begin
      reqFlag <= 1'b0;
    end else if (wrEna) begin
      reqFlag <= 1'b1;
    end else if (ackSel && reqFlag) begin
      reqFlag <= 1'b0;
    end else if (expire && enabled && !reqFlag) begin
      reqFlag <= 1'b1;
    end
  end

  // Interrupt: a new terminal count beats a clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (tcIn) begin
      irqFlag <= 1'b1;
    end else if (wrClr) begin
      irqFlag <= 1'b0;
    end
  end

  always_comb begin
    strb.loadLow  = wrDiv && !hiNext;
    strb.loadHigh = wrDiv && hiNext;
    strb.restart  = wrEna;
    strb.dacWrite = wrDac && !enabled;
  end

endmodule

// File: rtl/pacerData.sv
module pacerData
  import pacer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pacerStrb_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic              expire,
  output logic [DATA_W-1:0] dacData
);

  localparam int DIV_W = 2 * DATA_W;
  localparam int CNT_W = DIV_W + 1;

  logic [DATA_W-1:0] lowHold;
  logic [DIV_W-1:0]  divisor;
  logic [DIV_W-1:0]  newDiv;
  logic [CNT_W-1:0]  cnt;

  // Zero divisor stands for the full 2**DIV_W range
  function automatic logic [CNT_W-1:0] widen(input logic [DIV_W-1:0] d);
    return (d == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, d};
  endfunction

  assign newDiv = {wrData, lowHold};
  assign expire = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowHold <= '0;
    end else if (strb.loadLow) begin
      lowHold <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divisor <= '0;
    end else if (strb.loadHigh) begin
      divisor <= newDiv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= widen('0);
    end else if (strb.loadHigh) begin
      cnt <= widen(newDiv);
    end else if (strb.restart || expire) begin
      cnt <= widen(divisor);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacData <= '0;
    end else if (strb.dacWrite) begin
      dacData <= wrData;
    end
  end

endmodule

// File: rtl/dmaPacer.sv
module dmaPacer
  import pacer_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        baseSel,
  input  logic              chanSel,
  input  logic              irqSel,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic              ioWr,
  input  logic              dackCh1,
  input  logic              dackCh3,
  input  logic              tcIn,
  output logic              drqCh1,
  output logic              drqCh3,
  output logic              irqLine3,
  output logic              irqLine7,
  output logic [DATA_W-1:0] dacData
);

  pacerStrb_t strb;
  logic       expire;
  logic       reqFlag;
  logic       irqFlag;
  logic       ackSel;

  assign ackSel = chanSel ? dackCh3 : dackCh1;

  pacerCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baseSel  (baseSel),
    .ioAddr   (ioAddr),
    .ioWr     (ioWr),
    .modeBits (ioWrData[DATA_W-1 -: 2]),
    .ackSel   (ackSel),
    .tcIn     (tcIn),
    .expire   (expire),
    .strb     (strb),
    .reqFlag  (reqFlag),
    .irqFlag  (irqFlag)
  );

  pacerData #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (ioWrData),
    .expire  (expire),
    .dacData (dacData)
  );

  assign drqCh1   = reqFlag && !chanSel;
  assign drqCh3   = reqFlag && chanSel;
  assign irqLine3 = irqFlag && !irqSel;
  assign irqLine7 = irqFlag && irqSel;

endmodule

// File: rtl/pacer_chk.sv
module pacer_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        baseSel,
  input logic              chanSel,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWr,
  input logic              dackCh1,
  input logic              dackCh3,
  input logic              tcIn,
  input logic              drqCh1,
  input logic              drqCh3,
  input logic              irqLine3,
  input logic              irqLine7
);

  logic [5:0] winTag;
  logic       inWin;
  logic       reqAny;
  logic       irqAny;
  logic       ackOn;

  always_comb begin
    case (baseSel)
      2'd0:    winTag = 6'h22;
      2'd1:    winTag = 6'h24;
      2'd2:    winTag = 6'h28;
      default: winTag = 6'h2C;
    endcase
  end

  assign inWin  = ioWr && ioAddr[3] && (ioAddr[ADDR_W-1:4] == winTag);
  assign reqAny = drqCh1 || drqCh3;
  assign irqAny = irqLine3 || irqLine7;
  assign ackOn  = chanSel ? dackCh3 : dackCh1;

  // R9
  one_drq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({drqCh1, drqCh3}) <= 1);

  // R9
  one_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({irqLine3, irqLine7}) <= 1);

  // R8
  tc_sets_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    tcIn |=> irqAny);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqAny) |-> $past(inWin && (ioAddr[3:0] == 4'hC)));

  // R5
  disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && (ioAddr[3:0] == 4'hD)) |=> !reqAny);

  // R3
  enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && (ioAddr[3:0] == 4'hE)) |=> reqAny);

  // R4
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqAny && ackOn && !ioWr) |=> !reqAny);

endmodule

bind dmaPacer pacer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .baseSel  (baseSel),
  .chanSel  (chanSel),
  .ioAddr   (ioAddr),
  .ioWr     (ioWr),
  .dackCh1  (dackCh1),
  .dackCh3  (dackCh3),
  .tcIn     (tcIn),
  .drqCh1   (drqCh1),
  .drqCh3   (drqCh3),
  .irqLine3 (irqLine3),
  .irqLine7 (irqLine7)
);

// File: tb/dmaPacer_tb.sv
module dmaPacer_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] baseSel = 2'd0;
  logic       chanSel = 1'b0;
  logic       irqSel = 1'b0;
  logic [9:0] ioAddr = '0;
  logic [7:0] ioWrData = '0;
  logic       ioWr = 1'b0;
  logic       dackCh1 = 1'b0;
  logic       dackCh3 = 1'b0;
  logic       tcIn = 1'b0;
  logic       drqCh1, drqCh3, irqLine3, irqLine7;
  logic [7:0] dacData;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dmaPacer u_dut (
    .clk(clk), .rstN(rstN), .baseSel(baseSel), .chanSel(chanSel),
    .irqSel(irqSel), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr),
    .dackCh1(dackCh1), .dackCh3(dackCh3), .tcIn(tcIn),
    .drqCh1(drqCh1), .drqCh3(drqCh3), .irqLine3(irqLine3),
    .irqLine7(irqLine7), .dacData(dacData)
  );

  // {baseSel, address, data, expected dacData}
  localparam logic [27:0] VEC [8] = '{
    {2'd0, 10'h22F, 8'h11, 8'h11},
    {2'd0, 10'h24F, 8'h22, 8'h11},
    {2'd1, 10'h24F, 8'h33, 8'h33},
    {2'd2, 10'h28F, 8'h44, 8'h44},
    {2'd2, 10'h287, 8'h55, 8'h44},
    {2'd3, 10'h2CF, 8'h66, 8'h66},
    {2'd3, 10'h22F, 8'h77, 8'h66},
    {2'd1, 10'h34F, 8'h88, 8'h66}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ioWrite(input logic [9:0] a, input logic [7:0] d);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ack(input bit ch3);
    if (ch3) dackCh3 = 1'b1; else dackCh1 = 1'b1;
    @(negedge clk);
    dackCh1 = 1'b0; dackCh3 = 1'b0;
  endtask

  task automatic tcPulse();
    tcIn = 1'b1;
    @(negedge clk);
    tcIn = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R2 reset state
    chk("R2 drq1", drqCh1, 0);
    chk("R2 drq3", drqCh3, 0);
    chk("R2 irq", {irqLine3, irqLine7}, 0);
    chk("R2 dac", dacData, 0);

    // R1 decode table, DMA disabled
    for (int i = 0; i < 8; i++) begin
      baseSel = VEC[i][27:26];
      ioWrite(VEC[i][25:16], VEC[i][15:8]);
      chk("R1 decode", dacData, VEC[i][7:0]);
    end
    baseSel = 2'd0;

    // Divisor 5
    ioWrite(10'h22B, 8'h80);
    ioWrite(10'h22A, 8'd5);
    ioWrite(10'h22A, 8'd0);

    // R3 enable
    ioWrite(10'h22E, 8'hA5);
    chk("R3 drq1 after enable", drqCh1, 1);
    chk("R9 drq3 unselected", drqCh3, 0);
    // R4 ack then re-arm at N=5
    ack(0);
    chk("R4 drop on ack", drqCh1, 0);
    tick(3);
    chk("R4 low before expiry", drqCh1, 0);
    tick(1);
    chk("R4 rearm at expiry", drqCh1, 1);
    // R11 ack on the expiry edge
    tick(4);
    ack(0);
    chk("R11 ack wins", drqCh1, 0);
    tick(4);
    chk("R11 low until next expiry", drqCh1, 0);
    tick(1);
    chk("R11 rearm N later", drqCh1, 1);

    // R5 disable
    ioWrite(10'h22D, 8'h00);
    chk("R5 drop on disable", drqCh1, 0);
    tick(12);
    chk("R5 stays low", drqCh1, 0);

    // R6 low byte alone has no effect
    ioWrite(10'h22A, 8'd3);
    ioWrite(10'h22E, 8'h00);
    ack(0);
    tick(3);
    chk("R6 low only, still low", drqCh1, 0);
    tick(1);
    chk("R6 low only, period 5", drqCh1, 1);
    ack(0);
    ioWrite(10'h22A, 8'd0);
    tick(2);
    chk("R6 N=3 low", drqCh1, 0);
    tick(1);
    chk("R6 N=3 rearm", drqCh1, 1);

    // R7 byte-order rewind
    ioWrite(10'h22A, 8'd7);
    ioWrite(10'h22B, 8'h80);
    ioWrite(10'h22A, 8'd2);
    ioWrite(10'h22A, 8'd0);
    ioWrite(10'h22E, 8'h00);
    ack(0);
    chk("R7 low after ack", drqCh1, 0);
    tick(1);
    chk("R7 N=2 rearm", drqCh1, 1);

    // R9 channel routing
    chanSel = 1'b1;
    tick(1);
    chk("R9 drq3 selected", drqCh3, 1);
    chk("R9 drq1 unselected", drqCh1, 0);
    ack(0);
    chk("R9 ack ch1 ignored", drqCh3, 1);
    ack(1);
    chk("R9 ack ch3 drops", drqCh3, 0);

    // R8 interrupt
    tcPulse();
    chk("R8 irq3 set", irqLine3, 1);
    chk("R9 irq7 unselected", irqLine7, 0);
    tick(5);
    chk("R8 irq held", irqLine3, 1);
    irqSel = 1'b1;
    tick(1);
    chk("R9 irq7 selected", irqLine7, 1);
    chk("R9 irq3 off", irqLine3, 0);
    ioWrite(10'h22C, 8'h3C);
    chk("R8 cleared", irqLine7, 0);
    tcIn = 1'b1;
    ioWrite(10'h22C, 8'h00);
    tcIn = 1'b0;
    chk("R8 tc beats clear", irqLine7, 1);
    ioWrite(10'h22C, 8'hFF);
    chk("R8 cleared again", irqLine7, 0);

    // R10 DAC port
    ioWrite(10'h22F, 8'h99);
    chk("R10 ignored while enabled", dacData, 8'h66);
    ioWrite(10'h22D, 8'h00);
    ioWrite(10'h22F, 8'h5A);
    chk("R10 load while disabled", dacData, 8'h5A);

    // R6 zero divisor = 65536
    ioWrite(10'h22B, 8'h80);
    ioWrite(10'h22A, 8'd0);
    ioWrite(10'h22A, 8'd0);
    ioWrite(10'h22E, 8'h00);
    ack(1);
    tick(65534);
    chk("R6 zero divisor low", drqCh3, 0);
    tick(1);
    chk("R6 zero divisor rearm", drqCh3, 1);

    done = 1;
    summary();
    $finish;
  end

endmodule